// File: doc/BRIEF.md
# Codec Control Slot Command Engine

This block lets a host reach the control registers of an attached audio codec through two transmit slot words. The host first places the write data in the slot 2 transmit register, then writes a command word to the slot 1 transmit register. That second write launches the command. A command is either a register write or a register read.

A write command carries a 7-bit register index and a 16-bit value. A read command fetches a codec register. When the read finishes, the block loads an echo word into receive slot 1 and the result word into receive slot 2, then raises the receive-valid flags. The host polls a flag word to follow the exchange.

The serial frame timing is out of scope. A local register file stands in for the codec and answers over a one-cycle request/acknowledge port.

Top module: `codec_slot_engine`

## Requirements
- R1: After reset the flag word (host address 4) reads 0x07. Bit 0 is slot 1 transmit-empty, bit 1 is slot 2 transmit-empty, bit 2 is the combined empty flag, bits 3/4 are the receive-busy flags for slots 1/2, and bits 5/6 are the receive-valid flags for slots 1/2. Receive slot 1 (address 2) and receive slot 2 (address 3) both read zero.
- R2: A host write to address 0 (slot 1 transmit) stores the word, clears bit 0 of the flag word and launches a command. A host write to address 1 (slot 2 transmit) only stores data and clears bit 1. It launches nothing and leaves the busy and valid flags unchanged.
- R3: In the slot 1 word, bit 19 = 0 selects a write. The codec register index is bits 18:12 of the slot 1 word. The value written is bits 19:4 of the current slot 2 word.
- R4: In the slot 1 word, bit 19 = 1 selects a read. When the read completes, receive slot 1 holds the slot 1 word with bit 19 cleared and all other bits kept.
- R5: When a read completes, receive slot 2 holds the 16-bit register value in bits 19:4, with bits 3:0 zero.
- R6: Launching a read sets both receive-busy flags and clears both receive-valid flags in the next cycle. Completing the read clears both busy flags and sets both valid flags. A busy flag and the valid flag of the same slot are never set together.
- R7: A host read of receive slot 2 clears both receive-valid flags. A host read of receive slot 1 or of the flag word leaves them set.
- R8: The codec port acknowledges each request exactly one cycle after it, with read data alongside the acknowledge. Read results therefore appear in the receive slots two cycles after the launching slot 1 write.
- R9: A slot 1 write that arrives while a command is still in flight is discarded. The in-flight command and its results are unaffected.
- R10: The combined empty flag equals slot 1 transmit-empty AND slot 2 transmit-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read strobe; a read of address 3 clears the valid flags |
| host_addr | input | 3 | Host register select: 0 TX slot 1, 1 TX slot 2, 2 RX slot 1, 3 RX slot 2, 4 flags |
| host_wdata | input | 20 | Host write data |
| host_rdata | output | 20 | Combinational read data for host_addr; unused addresses read zero |

## Verification
Take E0 as the clock edge that accepts a slot 1 write. The busy flags are due straight after E0. After E1 the codec acknowledge is out but the receive slots must still be unchanged. The echo word, the result word and the valid flags are due after E2. The bench drives inputs and samples outputs on the falling edge. It counts these edges one by one after each launch, so each result is checked in the exact cycle it is due and not merely eventually. A write command is followed by two idle cycles before the next slot 1 write, except where the drop-while-busy case deliberately places one inside that window.

// File: rtl/cse_pkg.sv
package cse_pkg;
  localparam int SLOT_W  = 20;
  localparam int DIR_BIT = 19;
  localparam int IDX_W   = 7;
  localparam int IDX_LO  = 12;
  localparam int IDX_HI  = IDX_LO + IDX_W - 1;
  localparam int DAT_W   = 16;
  localparam int DAT_LO  = 4;
  localparam int DAT_HI  = DAT_LO + DAT_W - 1;
  localparam int FLAG_W  = 7;

  localparam int A_TX1   = 0;
  localparam int A_TX2   = 1;
  localparam int A_RX1   = 2;
  localparam int A_RX2   = 3;
  localparam int A_FLAGS = 4;

  typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_WAIT} seq_state_e;

  typedef struct packed {
    logic             rd;
    logic [IDX_W-1:0] idx;
    logic [DAT_W-1:0] dat;
  } codec_cmd_t;
endpackage

// File: rtl/cse_rst_sync.sv
module cse_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/cse_codec_regfile.sv
module cse_codec_regfile
  import cse_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  codec_cmd_t       cmd,
  output logic             ack,
  output logic [DAT_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DAT_W-1:0] mem [DEPTH];
  logic [DAT_W-1:0] rdata_q;
  logic             ack_q;

  always_ff @(posedge clk) begin
    if (req && !cmd.rd) mem[cmd.idx] <= cmd.dat;
  end

  always_ff @(posedge clk) begin
    if (req && cmd.rd) rdata_q <= mem[cmd.idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= req;
  end

  assign ack   = ack_q;
  assign rdata = rdata_q;

  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> ack);  // R8
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !ack);  // R8
endmodule

// File: rtl/cse_cmd_seq.sv
module cse_cmd_seq
  import cse_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  codec_cmd_t       cmd_in,
  output logic             idle,
  output logic             req,
  output codec_cmd_t       req_cmd,
  input  logic             ack,
  output logic             done_rd
);
  seq_state_e state_q, state_d;
  codec_cmd_t cmd_q, cmd_d;
  logic       start;

  assign start = launch && (state_q == SQ_IDLE);

  always_comb begin
    state_d = state_q;
    cmd_d   = cmd_q;
    unique case (state_q)
      SQ_IDLE: if (start) begin
        state_d = SQ_REQ;
        cmd_d   = cmd_in;
      end
      SQ_REQ:  state_d = SQ_WAIT;
      SQ_WAIT: if (ack) state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cmd_q   <= '0;
    end else begin
      state_q <= state_d;
      if (start) cmd_q <= cmd_d;
    end
  end

  assign idle    = (state_q == SQ_IDLE);
  assign req     = (state_q == SQ_REQ);
  assign req_cmd = cmd_q;
  assign done_rd = (state_q == SQ_WAIT) && ack && cmd_q.rd;

  AST_START_GIVES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> req);  // R2
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);  // R8
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(cmd_q));  // R9
endmodule

// File: rtl/codec_slot_engine.sv
module codec_slot_engine
  import cse_pkg::*;
#(
  parameter int HOST_AW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [SLOT_W-1:0]  host_wdata,
  output logic [SLOT_W-1:0]  host_rdata
);
  logic rst_ns;

  cse_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  logic [SLOT_W-1:0] tx1_q, tx1_d;
  logic [DAT_W-1:0]  tx2_q, tx2_d;
  logic [SLOT_W-1:0] rx1_q, rx1_d;
  logic [SLOT_W-1:0] rx2_q, rx2_d;
  logic              tx1e_q, tx1e_d, tx2e_q, tx2e_d;
  logic [1:0]        busy_q, busy_d, valid_q, valid_d;

  logic       sel_tx1, sel_tx2, sel_rx2;
  logic       seq_idle, launch, seq_req, codec_ack, done_rd;
  codec_cmd_t new_cmd, req_cmd;
  logic [DAT_W-1:0] codec_rdata;
  logic [FLAG_W-1:0] flags;

  assign sel_tx1 = host_addr == HOST_AW'(A_TX1);
  assign sel_tx2 = host_addr == HOST_AW'(A_TX2);
  assign sel_rx2 = host_addr == HOST_AW'(A_RX2);
  assign launch  = host_wr && sel_tx1 && seq_idle;

  assign new_cmd.rd  = host_wdata[DIR_BIT];
  assign new_cmd.idx = host_wdata[IDX_HI:IDX_LO];
  assign new_cmd.dat = tx2_q;

  cse_cmd_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_ns),
    .launch  (launch),
    .cmd_in  (new_cmd),
    .idle    (seq_idle),
    .req     (seq_req),
    .req_cmd (req_cmd),
    .ack     (codec_ack),
    .done_rd (done_rd)
  );

  cse_codec_regfile u_codec (
    .clk   (clk),
    .rst_n (rst_ns),
    .req   (seq_req),
    .cmd   (req_cmd),
    .ack   (codec_ack),
    .rdata (codec_rdata)
  );

  always_comb begin
    tx1_d   = tx1_q;
    tx2_d   = tx2_q;
    rx1_d   = rx1_q;
    rx2_d   = rx2_q;
    tx1e_d  = tx1e_q;
    tx2e_d  = tx2e_q;
    busy_d  = busy_q;
    valid_d = valid_q;
    if (launch) begin
      tx1_d  = host_wdata;
      tx1e_d = 1'b0;
      if (host_wdata[DIR_BIT]) begin
        busy_d  = 2'b11;
        valid_d = 2'b00;
      end
    end
    if (host_wr && sel_tx2) begin
      tx2_d  = host_wdata[DAT_HI:DAT_LO];
      tx2e_d = 1'b0;
    end
    if (host_rd && sel_rx2) valid_d = 2'b00;
    if (done_rd) begin
      rx1_d          = tx1_q;
      rx1_d[DIR_BIT] = 1'b0;
      rx2_d          = {codec_rdata, {DAT_LO{1'b0}}};
      busy_d         = 2'b00;
      valid_d        = 2'b11;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      tx1_q   <= '0;
      tx2_q   <= '0;
      rx1_q   <= '0;
      rx2_q   <= '0;
      tx1e_q  <= 1'b1;
      tx2e_q  <= 1'b1;
      busy_q  <= '0;
      valid_q <= '0;
    end else begin
      if (launch) tx1_q <= tx1_d;
      if (host_wr && sel_tx2) tx2_q <= tx2_d;
      if (done_rd) begin
        rx1_q <= rx1_d;
        rx2_q <= rx2_d;
      end
      tx1e_q  <= tx1e_d;
      tx2e_q  <= tx2e_d;
      busy_q  <= busy_d;
      valid_q <= valid_d;
    end
  end

  assign flags = {valid_q[1], valid_q[0], busy_q[1], busy_q[0],
                  tx1e_q & tx2e_q, tx2e_q, tx1e_q};

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      HOST_AW'(A_RX1):   host_rdata = rx1_q;
      HOST_AW'(A_RX2):   host_rdata = rx2_q;
      HOST_AW'(A_FLAGS): host_rdata = SLOT_W'(flags);
      default:           host_rdata = '0;
    endcase
  end

  AST_TX1_EMPTY_CLR: assert property (@(posedge clk) disable iff (!rst_ns)
    launch |=> !tx1e_q);  // R2
  AST_BUSY_VALID_EXCL: assert property (@(posedge clk) disable iff (!rst_ns)
    !(busy_q[0] && valid_q[0]) && !(busy_q[1] && valid_q[1]));  // R6
  AST_ECHO_DIR_CLR: assert property (@(posedge clk) disable iff (!rst_ns)
    done_rd |=> !rx1_q[DIR_BIT] && valid_q[0]);  // R4
  AST_RX2_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_ns)
    valid_q[1] |-> rx2_q[DAT_LO-1:0] == '0);  // R5
  AST_DROP_KEEPS_TX1: assert property (@(posedge clk) disable iff (!rst_ns)
    (host_wr && sel_tx1 && !seq_idle) |=> $stable(tx1_q));  // R9
endmodule

// File: tb/sim_codec_slot_engine.sv
module sim_codec_slot_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic [19:0] host_wdata = 20'd0;
  logic [19:0] host_rdata;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [128];

  always #10 clk = ~clk;

  codec_slot_engine u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata)
  );

  function automatic logic [19:0] exp_flags(logic t1, logic t2, logic b, logic v);
    return {13'd0, v, v, b, b, t1 & t2, t2, t1};
  endfunction
  function automatic logic [19:0] exp_echo(logic [19:0] w);
    return w & 20'h7FFFF;
  endfunction
  function automatic logic [19:0] exp_rx2(logic [15:0] v);
    return {v, 4'h0};
  endfunction

  task automatic check(string req, logic [19:0] act, logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%05h expected 0x%05h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [19:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [19:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, output logic [19:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [19:0] v, w1, first;
    logic [6:0]  idx;
    logic [15:0] dat;
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED0042);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    peek(3'd4, v); check("R1 flags after reset", v, exp_flags(1, 1, 0, 0));
    peek(3'd2, v); check("R1 rx1 after reset", v, 20'h0);
    peek(3'd3, v); check("R1 rx2 after reset", v, 20'h0);

    // slot 2 write only: no command, tx2 empty drops, combined drops
    wr(3'd1, {16'hBEEF, 4'hA});
    peek(3'd4, v); check("R2 R10 flags after slot2 write", v, exp_flags(1, 0, 0, 0));
    @(negedge clk);
    peek(3'd4, v); check("R2 slot2 write launches nothing", v, exp_flags(1, 0, 0, 0));

    // write command idx 5
    wr(3'd0, {1'b0, 7'd5, 12'h123});
    model[5] = 16'hBEEF;
    peek(3'd4, v); check("R2 slot1 write clears tx1 empty", v, exp_flags(0, 0, 0, 0));
    repeat (2) @(negedge clk);

    // read command idx 5 with exact timing
    w1 = {1'b1, 7'd5, 12'hABC};
    wr(3'd0, w1);
    peek(3'd4, v); check("R6 busy right after launch", v, exp_flags(0, 0, 1, 0));
    @(negedge clk);
    peek(3'd4, v); check("R8 no result one cycle after launch", v, exp_flags(0, 0, 1, 0));
    @(negedge clk);
    peek(3'd4, v); check("R8 R6 valid two cycles after launch", v, exp_flags(0, 0, 0, 1));
    peek(3'd2, v); check("R4 echo word", v, exp_echo(w1));
    peek(3'd3, v); check("R5 R3 result word", v, exp_rx2(model[5]));

    rd(3'd2, v);
    peek(3'd4, v); check("R7 rx1 read keeps valid", v, exp_flags(0, 0, 0, 1));
    rd(3'd3, v);
    peek(3'd4, v); check("R7 rx2 read clears valid", v, exp_flags(0, 0, 0, 0));

    // corner indices and data
    wr(3'd1, {16'hFFFF, 4'h0}); wr(3'd0, {1'b0, 7'd127, 12'h000}); model[127] = 16'hFFFF;
    repeat (2) @(negedge clk);
    wr(3'd1, {16'h0000, 4'hF}); wr(3'd0, {1'b0, 7'd0, 12'hFFF}); model[0] = 16'h0000;
    repeat (2) @(negedge clk);
    wr(3'd0, {1'b1, 7'd127, 12'h001}); repeat (2) @(negedge clk);
    peek(3'd3, v); check("R3 R5 index 127 all ones", v, exp_rx2(16'hFFFF));
    wr(3'd0, {1'b1, 7'd0, 12'hFFF}); repeat (2) @(negedge clk);
    peek(3'd3, v); check("R3 R5 index 0 zero data", v, exp_rx2(16'h0000));
    peek(3'd2, v); check("R4 echo index 0", v, exp_echo({1'b1, 7'd0, 12'hFFF}));

    // second slot 1 write during flight is dropped
    first = {1'b1, 7'd5, 12'h055};
    wr(3'd0, first);
    host_wr = 1'b1; host_addr = 3'd0; host_wdata = {1'b1, 7'd127, 12'h0AA};
    @(negedge clk); host_wr = 1'b0;
    @(negedge clk);
    peek(3'd2, v); check("R9 dropped write keeps echo", v, exp_echo(first));
    peek(3'd3, v); check("R9 dropped write keeps result", v, exp_rx2(model[5]));
    repeat (2) @(negedge clk);
    peek(3'd4, v); check("R9 no second command ran", v, exp_flags(0, 0, 0, 1));

    // random write then read back
    for (int i = 0; i < 40; i++) begin
      idx = 7'($urandom);
      dat = 16'($urandom);
      wr(3'd1, {dat, 4'($urandom)});
      wr(3'd0, {1'b0, idx, 12'($urandom)});
      model[idx] = dat;
      repeat (2) @(negedge clk);
      w1 = {1'b1, idx, 12'($urandom)};
      wr(3'd0, w1);
      repeat (2) @(negedge clk);
      peek(3'd2, v); check("R4 random echo", v, exp_echo(w1));
      peek(3'd3, v); check("R3 R5 random result", v, exp_rx2(model[idx]));
      rd(3'd3, v);
      peek(3'd4, v); check("R7 random clear", v, exp_flags(0, 0, 0, 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule